// File: doc/BRIEF.md
# Dual-Source UART Bit-Rate Tick Generator

This block times the bits of a UART. It produces a one-cycle tick at the programmed bit rate. A single configuration register picks one of two timing sources. The first is the block clock divided by four. The second is a crystal strobe input, passed through a prescaler that a two-bit code selects. The chosen source then feeds a 23-bit reload divider that counts programmed value plus one. The register is written and read back over a plain write/read port.

Everything runs in one clock domain. The crystal timing arrives as a strobe input that is high for one cycle per crystal period. A small state machine controls the counters through three states. ST_OFF holds them cleared while the enable bit is clear. ST_ARM is the single cleared cycle that follows any register write that leaves the block enabled. ST_RUN lets them count.

The transitions are as follows. A write with the enable bit set moves to ST_ARM, and a write with it clear moves to ST_OFF. ST_ARM always moves to ST_RUN on the next cycle. Without a write, ST_RUN and ST_OFF stay where they are. The parameter `LEGACY_FIXED` selects the older revision, in which the prescale code is not stored and the crystal path always divides by 3.

Top module: `baud_tick_gen`

## Requirements
- R1: After synchronous reset the readback value is 0 and no tick is produced.
- R2: Readback returns the divisor in bits [22:0], the enable in bit 23, the source select in bit 24 and the prescale code in bits [27:26]. Bits 25 and 31:28 always read 0.
- R3: While the enable bit (bit 23) is 0, the tick stays low even if a divisor and a source are programmed.
- R4: With bit 24 = 0, the source is the block clock divided by 4, so the tick period is 4*(N+1) cycles, where N is the divisor field.
- R5: With bit 24 = 1 and the strobe held high, the prescale code gives the ratio P as follows: 00 gives 3, 01 gives 1, 10 gives 2 and 11 gives 2. The tick period is P*(N+1) cycles.
- R6: On the crystal path only cycles with the strobe high advance the prescaler, so a strobe on every other cycle doubles the period.
- R7: A divisor field of 0 gives one tick per source pulse, down to a tick on every cycle.
- R8: Any write restarts timing. The tick is low in the cycle the write takes effect, and the first tick comes R*(N+1)+1 cycles after the write edge, where R is the source ratio.
- R9: The tick is a single-cycle pulse whenever the period is more than one cycle.
- R10: With LEGACY_FIXED = 1, bits [27:26] read 0 and the crystal path always divides by 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 32 | Register write value |
| rdata | output | 32 | Register readback |
| xtal_stb | input | 1 | One pulse per crystal period |
| baud_tick | output | 1 | Bit-rate tick |

## Verification
The system-clock path is run with divisors 2 and 0. This separates the fixed divide-by-4 from the reload count and shows the minus-one offset. All four prescale codes are run on the crystal path with the strobe held high. This exposes any mix-up in the non-linear table, including the repeated ratio 2. A strobe that toggles every cycle shows whether the prescaler counts strobes or clocks.

The first-tick latency after every write separates a clean restart from a runt period. A register write with the enable clear, and a legacy instance driven alongside, check that the tick stays silent and that the fixed divide-by-3 applies.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;
    localparam int CFG_W     = 32;
    localparam int DIV_W     = 23;
    localparam int EN_BIT    = 23;
    localparam int SRC_BIT   = 24;
    localparam int CODE_LO   = 26;
    localparam int CODE_W    = 2;
    localparam int PRE_W     = 3;
    localparam int SYS_RATIO = 4;

    typedef enum logic [1:0] {ST_OFF, ST_ARM, ST_RUN} bg_state_t;

    function automatic logic [PRE_W-1:0] xtal_ratio(input logic [CODE_W-1:0] code);
        logic [PRE_W-1:0] r;
        unique case (code)
            2'b00:   r = PRE_W'(3);
            2'b01:   r = PRE_W'(1);
            default: r = PRE_W'(2);
        endcase
        return r;
    endfunction
endpackage

// File: rtl/baud_cfg_reg.sv
module baud_cfg_reg
    import baud_gen_pkg::*;
#(
    parameter bit LEGACY_FIXED = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CFG_W-1:0]  wdata,
    output logic [DIV_W-1:0]  div_o,
    output logic              en_o,
    output logic              src_o,
    output logic [CODE_W-1:0] code_o,
    output logic [CFG_W-1:0]  rdata_o
);
    logic [DIV_W-1:0] div_q;
    logic             en_q;
    logic             src_q;
    logic             unused_wbits;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
            en_q  <= 1'b0;
            src_q <= 1'b0;
        end else if (wr_en) begin
            div_q <= wdata[DIV_W-1:0];
            en_q  <= wdata[EN_BIT];
            src_q <= wdata[SRC_BIT];
        end
    end

    generate
        if (LEGACY_FIXED) begin : g_fixed
            assign code_o       = '0;
            assign unused_wbits = ^{wdata[CFG_W-1:CODE_LO], wdata[SRC_BIT+1]};
        end else begin : g_sel
            logic [CODE_W-1:0] code_q;
            always_ff @(posedge clk) begin
                if (rst)        code_q <= '0;
                else if (wr_en) code_q <= wdata[CODE_LO +: CODE_W];
            end
            assign code_o       = code_q;
            assign unused_wbits = ^{wdata[CFG_W-1:CODE_LO+CODE_W], wdata[SRC_BIT+1]};
        end
    endgenerate

    assign div_o = div_q;
    assign en_o  = en_q;
    assign src_o = src_q;

    always_comb begin
        rdata_o                      = '0;
        rdata_o[DIV_W-1:0]           = div_q;
        rdata_o[EN_BIT]              = en_q;
        rdata_o[SRC_BIT]             = src_q;
        rdata_o[CODE_LO +: CODE_W]   = code_o;
    end

    // R1: reset leaves a zero readback
    a_r1_reset_clear: assert property (@(posedge clk) rst |=> (rdata_o == '0));

    generate
        if (LEGACY_FIXED) begin : g_chk
            // R10: legacy prescale bits never read back
            a_r10_legacy_code: assert property (@(posedge clk) disable iff (rst)
                wr_en |=> (rdata_o[CODE_LO +: CODE_W] == '0));
        end
    endgenerate
endmodule

// File: rtl/baud_prescaler.sv
module baud_prescaler
    import baud_gen_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic             stb_i,
    input  logic [PRE_W-1:0] ratio_i,
    output logic             pulse_o
);
    localparam logic [PRE_W-1:0] ONE = PRE_W'(1);
    logic [PRE_W-1:0] cnt_q;
    logic             last;

    assign last    = (cnt_q == ratio_i - ONE);
    assign pulse_o = run_i & stb_i & last;

    always_ff @(posedge clk) begin
        if (rst || !run_i)  cnt_q <= '0;
        else if (stb_i)     cnt_q <= last ? '0 : cnt_q + ONE;
    end

    // R4: the prescale count stays below the selected ratio while running
    a_r4_pre_bound: assert property (@(posedge clk) disable iff (rst)
        run_i |-> (cnt_q < ratio_i));
endmodule

// File: rtl/baud_reload_div.sv
module baud_reload_div
    import baud_gen_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic             pulse_i,
    input  logic             kill_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);
    logic [DIV_W-1:0] cnt_q;
    logic             term;
    logic             tick_q;

    assign term = pulse_i & (cnt_q == div_i);

    always_ff @(posedge clk) begin
        if (rst || !run_i)  cnt_q <= '0;
        else if (pulse_i)   cnt_q <= (cnt_q == div_i) ? '0 : cnt_q + ONE;
    end

    always_ff @(posedge clk) begin
        if (rst) tick_q <= 1'b0;
        else     tick_q <= term & ~kill_i;
    end

    assign tick_o = tick_q;

    // R7: the reload count never passes the programmed divisor while running
    a_r7_div_bound: assert property (@(posedge clk) disable iff (rst)
        run_i |-> (cnt_q <= div_i));
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
    import baud_gen_pkg::*;
#(
    parameter bit LEGACY_FIXED = 1'b0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    input  logic        xtal_stb,
    output logic        baud_tick
);
    bg_state_t         state_q, state_d;
    logic [DIV_W-1:0]  div_n;
    logic              cfg_en;
    logic              cfg_src;
    logic [CODE_W-1:0] cfg_code;
    logic              run;
    logic [PRE_W-1:0]  ratio;
    logic              src_stb;
    logic              src_pulse;

    baud_cfg_reg #(.LEGACY_FIXED(LEGACY_FIXED)) u_cfg (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wdata(wdata),
        .div_o(div_n), .en_o(cfg_en), .src_o(cfg_src), .code_o(cfg_code),
        .rdata_o(rdata)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_OFF;
        else     state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            state_d = wdata[EN_BIT] ? ST_ARM : ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF:  state_d = ST_OFF;
                ST_ARM:  state_d = ST_RUN;
                ST_RUN:  state_d = ST_RUN;
                default: state_d = ST_OFF;
            endcase
        end
    end

    // Outputs of the state machine and source selection
    always_comb begin
        run     = (state_q == ST_RUN);
        ratio   = cfg_src ? xtal_ratio(cfg_code) : PRE_W'(SYS_RATIO);
        src_stb = cfg_src ? xtal_stb : 1'b1;
    end

    baud_prescaler u_pre (
        .clk(clk), .rst(rst), .run_i(run), .stb_i(src_stb),
        .ratio_i(ratio), .pulse_o(src_pulse)
    );

    baud_reload_div u_div (
        .clk(clk), .rst(rst), .run_i(run), .pulse_i(src_pulse),
        .kill_i(wr_en), .div_i(div_n), .tick_o(baud_tick)
    );

    // R3: no tick while disabled
    a_r3_off_quiet: assert property (@(posedge clk) disable iff (rst)
        !cfg_en |-> !baud_tick);
    // R8: a write silences the tick for the cycle it lands
    a_r8_restart_quiet: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !baud_tick);
    // R9: a one-cycle tick unless every source pulse ticks on every cycle
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
        (baud_tick && !(cfg_src && ratio == PRE_W'(1) && div_n == '0)) |=> !baud_tick);
endmodule

// File: tb/baud_tick_gen_tb.sv
module baud_tick_gen_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata, rdata_old;
    logic        xtal_stb = 1'b1;
    logic        stb_toggle = 1'b0;
    logic        baud_tick, tick_old;

    int errors = 0;
    int checks = 0;
    int cnt = 0;
    int q[$];
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    baud_tick_gen #(.LEGACY_FIXED(1'b0)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
        .xtal_stb(xtal_stb), .baud_tick(baud_tick)
    );

    baud_tick_gen #(.LEGACY_FIXED(1'b1)) u_dut_old (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wdata(wdata), .rdata(rdata_old),
        .xtal_stb(xtal_stb), .baud_tick(tick_old)
    );

    always @(negedge clk) begin
        if (stb_toggle) xtal_stb <= ~xtal_stb;
        else            xtal_stb <= 1'b1;
    end

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: compare the gap before each tick against the scoreboard queue
    always @(posedge clk) begin
        #1;
        if (rst || wr_en) begin
            cnt = 0;
        end else begin
            cnt++;
            if (baud_tick) begin
                if (q.size() == 0) begin
                    check("R3 unexpected tick", 1, 0);
                end else begin
                    int e;
                    e = q.pop_front();
                    if (e >= 0) check("R4/R5/R6/R7/R8 tick spacing", cnt, e);
                end
                cnt = 0;
            end
        end
    end

    function automatic logic [31:0] cfg(input bit en, input bit src,
                                        input logic [1:0] code, input int n);
        logic [31:0] v;
        v = '0;
        v[22:0]  = 23'(n);
        v[23]    = en;
        v[24]    = src;
        v[27:26] = code;
        return v;
    endfunction

    task automatic write_cfg(input logic [31:0] v, input int first,
                             input int per, input int nper);
        q.delete();
        if (v[23]) begin
            q.push_back(first);
            for (int i = 0; i < nper; i++) q.push_back(per);
        end
        @(negedge clk);
        wr_en = 1'b1;
        wdata = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_drain(input string tag);
        for (int i = 0; i < 3000 && q.size() != 0; i++) @(negedge clk);
        check(tag, q.size(), 0);
    endtask

    initial begin
        int n_old;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check("R1 readback after reset", rdata, 0);
        check("R1 legacy readback after reset", rdata_old, 0);
        repeat (20) @(negedge clk);
        check("R1 no tick after reset", baud_tick, 0);

        // R2 / R10: readback of all defined fields, unused bits zero
        write_cfg(32'hFFFF_FFFF, -1, 0, 0);
        q.delete();
        check("R2 readback mask", rdata, 32'h0DFF_FFFF);
        check("R10 legacy readback mask", rdata_old, 32'h01FF_FFFF);

        // R4 / R8: system path, N=2
        write_cfg(cfg(1, 0, 2'b00, 2), 13, 12, 3);
        wait_drain("R4 sys path N=2 ticks seen");
        // R7: system path, N=0
        write_cfg(cfg(1, 0, 2'b00, 0), 5, 4, 3);
        wait_drain("R7 sys path N=0 ticks seen");

        // R5: crystal prescale table, strobe held high
        write_cfg(cfg(1, 1, 2'b00, 1), 7, 6, 3);
        wait_drain("R5 code 00 ratio 3");
        write_cfg(cfg(1, 1, 2'b01, 1), 3, 2, 3);
        wait_drain("R5 code 01 ratio 1");
        write_cfg(cfg(1, 1, 2'b10, 1), 5, 4, 3);
        wait_drain("R5 code 10 ratio 2");
        write_cfg(cfg(1, 1, 2'b11, 1), 5, 4, 3);
        wait_drain("R5 code 11 ratio 2");

        // R7: tick on every cycle
        write_cfg(cfg(1, 1, 2'b01, 0), 2, 1, 4);
        wait_drain("R7 crystal N=0 ratio 1");

        // R6: strobe on every other cycle doubles the period
        stb_toggle = 1'b1;
        write_cfg(cfg(1, 1, 2'b00, 1), -1, 12, 3);
        wait_drain("R6 strobe-gated prescaler");
        stb_toggle = 1'b0;

        // R10: legacy instance divides the crystal by 3 regardless of code
        write_cfg(cfg(1, 1, 2'b01, 1), 3, 2, 39);
        n_old = 0;
        for (int k = 1; k < 80; k++) begin
            @(negedge clk);
            if (k >= 20 && tick_old) n_old++;
        end
        check("R10 legacy ticks in 60 cycles", n_old, 10);
        check("R10 legacy code bits read 0", rdata_old[27:26], 0);
        wait_drain("R10 companion ticks seen");

        // R3: programmed but disabled, no tick (monitor flags any)
        write_cfg(cfg(0, 0, 2'b00, 0), 0, 0, 0);
        check("R3 readback of disabled config", rdata, 32'h0000_0000);
        repeat (40) @(negedge clk);
        check("R3 tick low while disabled", baud_tick, 0);
        write_cfg(cfg(0, 1, 2'b01, 5), 0, 0, 0);
        check("R2 readback without enable", rdata, 32'h0500_0005);
        repeat (40) @(negedge clk);
        check("R3 tick low with fields set", baud_tick, 0);

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule